// File: doc/BRIEF.md
# Mask-Driven Bit Centrifuge Unit

This block rearranges the bits of a 128-bit source word under a 128-bit mask. The word is handled as two separate 64-bit lanes, and each lane uses only its own half of the mask. Inside a lane, the source bits selected by a 1 in the mask move to the least significant end. The remaining bits move to the most significant end. Each group keeps its original relative order, so the lane is split into two order-preserving halves at once.

Operands arrive over a valid/ready handshake. Each operand carries the source, the mask, a vector-enable flag and the 32-bit instruction word. The unit checks that the instruction word is this one operation. It then returns either the rearranged word or a single flag: instruction not recognised, or vector unit disabled. Only one operation is in flight at a time. The result appears a fixed two cycles after acceptance. It is held at the output until the consumer takes it.

Top module: `bit_centrifuge`

## Requirements
- R1: The upper lane (bits 127:64) and the lower lane (bits 63:0) are processed independently. The result of each lane depends only on that lane's source and mask bits.
- R2: Within a lane, the source bits whose mask bit is 1 occupy the lowest result positions of the lane. The one with the lowest source index goes to lane bit 0, and their relative order is kept.
- R3: Within a lane, the source bits whose mask bit is 0 occupy the highest result positions of the lane. The one with the highest source index goes to lane bit 63, and their relative order is kept.
- R4: A lane whose mask is all zeros, or all ones, returns its source bits unchanged.
- R5: When the instruction is recognised and `in_vec_en` is 0, the output carries `out_unavail`=1, `out_badop`=0 and a zero result.
- R6: An instruction word is recognised when bits 31:26 equal 4 and bits 10:0 equal 1357, which gives 0x1000054D with zero register fields. Bits 25:11 are ignored. Any other word gives `out_badop`=1, `out_unavail`=0 and a zero result, whatever the value of `in_vec_en`.
- R7: An operand accepted at a clock edge (`in_valid` and `in_ready` both high) makes `out_valid` go high after the second following edge, and not after the first.
- R8: `in_ready` is low from the edge that accepts an operand until the result has been consumed. While `in_ready` is low, `in_valid` is ignored.
- R9: While `out_valid` is high and `out_ready` is low, `out_result`, `out_unavail` and `out_badop` stay stable. An edge with `out_ready` high consumes the result, and `out_valid` then drops.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit can accept an operand |
| in_src | input | 128 | Source word, upper lane in bits 127:64 |
| in_mask | input | 128 | Partition mask, same lane layout |
| in_vec_en | input | 1 | Vector unit enabled |
| in_insn | input | 32 | Instruction word to be checked |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 128 | Rearranged word, zero when a flag is set |
| out_unavail | output | 1 | Vector unit disabled, no result produced |
| out_badop | output | 1 | Instruction word not recognised |

## Verification
The hardest case to reach from the ports is an operand offered while the unit is busy or holding a result. A faulty ready path would let that operand replace the held value without any visible handshake. The stimulus therefore keeps `out_ready` low for several cycles after each result and drives `in_valid` with different data during that time. It then checks that the held output is unchanged and that no extra result appears after consumption. The bit placement is compared against a loop model that walks the big-endian bit numbering. This is done for random masks and for directed masks: alternating bits, a single 1, a single 0, all zeros, all ones and unequal lane masks.

// File: rtl/bit_centrifuge.sv
module bit_centrifuge #(
  parameter int          LANE_W = 64,
  parameter int          LANES  = 2,
  parameter logic [5:0]  PRI_OP = 6'd4,
  parameter logic [10:0] EXT_OP = 11'd1357
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [LANE_W*LANES-1:0]   in_src,
  input  logic [LANE_W*LANES-1:0]   in_mask,
  input  logic                      in_vec_en,
  input  logic [31:0]               in_insn,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [LANE_W*LANES-1:0]   out_result,
  output logic                      out_unavail,
  output logic                      out_badop
);
  localparam int          DW       = LANE_W * LANES;
  localparam logic [31:0] DEC_MASK = {6'h3F, 15'h0, 11'h7FF};
  localparam logic [31:0] DEC_WORD = {PRI_OP, 15'h0, EXT_OP};

  logic          s1_v, s1_en, s1_dec;
  logic [DW-1:0] s1_src, s1_msk, res_c;

  assign in_ready = !s1_v && !out_valid;

  wire take   = in_valid && in_ready;
  wire dec_ok = (in_insn & DEC_MASK) == DEC_WORD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_en  <= 1'b0;
      s1_dec <= 1'b0;
      s1_src <= '0;
      s1_msk <= '0;
    end else begin
      s1_v <= take;
      if (take) begin
        s1_en  <= in_vec_en;
        s1_dec <= dec_ok;
        s1_src <= in_src;
        s1_msk <= in_mask;
      end
    end
  end

  // Mask-1 bits rise from the lane bottom, mask-0 bits fall from the lane top.
  always_comb begin
    int ones;
    int zeros;
    res_c = '0;
    for (int l = 0; l < LANES; l++) begin
      ones  = 0;
      zeros = 0;
      for (int k = 0; k < LANE_W; k++) begin
        if (s1_msk[l*LANE_W + k]) begin
          res_c[l*LANE_W + ones] = s1_src[l*LANE_W + k];
          ones = ones + 1;
        end
      end
      for (int k = LANE_W - 1; k >= 0; k--) begin
        if (!s1_msk[l*LANE_W + k]) begin
          res_c[l*LANE_W + LANE_W - 1 - zeros] = s1_src[l*LANE_W + k];
          zeros = zeros + 1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_unavail <= 1'b0;
      out_badop   <= 1'b0;
    end else if (s1_v) begin
      out_valid   <= 1'b1;
      out_badop   <= !s1_dec;
      out_unavail <= s1_dec && !s1_en;
      out_result  <= (s1_dec && s1_en) ? res_c : '0;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_pop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v |-> $countones(res_c) == $countones(s1_src));
  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !out_valid ##1 out_valid);
  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_result)
      && $stable(out_unavail) && $stable(out_badop));
  p_noresult_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_unavail || out_badop)) |-> out_result == '0);
  p_oneflag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_unavail, out_badop}));
endmodule

// File: tb/test_bit_centrifuge.sv
module test_bit_centrifuge;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_src = '0;
  logic [127:0] in_mask = '0;
  logic         in_vec_en = 1'b0;
  logic [31:0]  in_insn = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [127:0] out_result;
  logic         out_unavail;
  logic         out_badop;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  localparam logic [31:0] GOOD = 32'h1000054D;

  always #2 clk = ~clk;

  bit_centrifuge i_bit_centrifuge (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src(in_src), .in_mask(in_mask), .in_vec_en(in_vec_en),
    .in_insn(in_insn), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_unavail(out_unavail), .out_badop(out_badop));

  task automatic chk(input bit ok, input string req,
                     input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Walks bits in big-endian numbering: doubleword 0 is bits 127:64.
  function automatic logic [127:0] model(logic [127:0] s, logic [127:0] m);
    logic [127:0] r = '0;
    for (int d = 0; d < 2; d++) begin
      int base = (1 - d) * 64;
      int p0 = 0;
      int p1 = 0;
      for (int j = 0; j < 64; j++) begin
        if (!m[base + 63 - j]) begin
          r[base + 63 - p0] = s[base + 63 - j];
          p0++;
        end
        if (m[base + j]) begin
          r[base + p1] = s[base + j];
          p1++;
        end
      end
    end
    return r;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic run_op(input logic [127:0] s, input logic [127:0] m,
                        input bit en, input logic [31:0] insn,
                        input int hold, input string req,
                        input bit use_exp, input logic [127:0] exp_in);
    logic [127:0] exp_r;
    bit bad;
    bad = (insn & 32'hFC0007FF) != GOOD;
    exp_r = use_exp ? exp_in : model(s, m);
    if (bad || !en) exp_r = '0;
    while (!in_ready) @(negedge clk);
    in_src = s; in_mask = m; in_vec_en = en; in_insn = insn; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(!out_valid, "R7 early valid", 128'(out_valid), 128'(0));
    chk(!in_ready, "R8 ready while busy", 128'(in_ready), 128'(0));
    @(negedge clk);
    chk(out_valid, "R7 valid after two edges", 128'(out_valid), 128'(1));
    chk(out_result == exp_r, req, out_result, exp_r);
    chk(out_badop == bad, "R6 badop flag", 128'(out_badop), 128'(bad));
    chk(out_unavail == (!bad && !en), "R5 unavail flag",
        128'(out_unavail), 128'(!bad && !en));
    for (int h = 0; h < hold; h++) begin
      in_src = ~s; in_mask = ~m; in_vec_en = 1'b1; in_insn = GOOD; in_valid = 1'b1;
      @(negedge clk);
      chk(out_valid && out_result == exp_r, "R9 hold / R8 ignore",
          out_result, exp_r);
      chk(!in_ready, "R8 ready while holding", 128'(in_ready), 128'(0));
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid, "R9 consume drops valid", 128'(out_valid), 128'(0));
    chk(in_ready, "R8 ready after consume", 128'(in_ready), 128'(1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [127:0] s, m;
    repeat (3) @(negedge clk);
    chk(!out_valid, "R10 reset valid", 128'(out_valid), 128'(0));
    chk(in_ready, "R10 reset ready", 128'(in_ready), 128'(1));
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3 hand case: top nibble of lower lane is mask-1, src 0xA...01 -> 0x1A
    run_op({64'h0, 64'hA000_0000_0000_0001}, {64'h0, 64'hF000_0000_0000_0000},
           1'b1, GOOD, 0, "R2 R3 hand-computed lane", 1'b1,
           {64'h0, 64'h0000_0000_0000_001A});
    s = rnd128();
    run_op(s, '0, 1'b1, GOOD, 1, "R4 all-zero mask", 1'b1, s);
    run_op(s, '1, 1'b1, GOOD, 0, "R4 all-ones mask", 1'b1, s);
    run_op(rnd128(), {2{64'hAAAA_AAAA_AAAA_AAAA}}, 1'b1, GOOD, 0,
           "R2 R3 alternating mask", 1'b0, '0);
    run_op(rnd128(), {64'h0000_0100_0000_0000, 64'h8000_0000_0000_0000},
           1'b1, GOOD, 0, "R2 single one", 1'b0, '0);
    run_op(rnd128(), {64'hFFFF_FFFF_FFFE_FFFF, 64'hFFFF_FFFF_FFFF_FFFE},
           1'b1, GOOD, 0, "R3 single zero", 1'b0, '0);
    run_op(rnd128(), {64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, 1'b1, GOOD, 2,
           "R1 unequal lane masks", 1'b0, '0);
    run_op(rnd128(), {64'h0F0F_00FF_1234_8000, 64'h0}, 1'b1, GOOD, 0,
           "R1 lower lane untouched", 1'b0, '0);
    run_op(rnd128(), rnd128(), 1'b0, GOOD, 1, "R5 disabled gives zero",
           1'b0, '0);
    run_op(rnd128(), rnd128(), 1'b1, GOOD | 32'h03FF_F800, 0,
           "R6 register fields ignored", 1'b0, '0);
    run_op(rnd128(), rnd128(), 1'b1, 32'h1000054C, 0, "R6 wrong extended op",
           1'b0, '0);
    run_op(rnd128(), rnd128(), 1'b0, 32'h1400054D, 0, "R6 badop over disable",
           1'b0, '0);

    for (int n = 0; n < 300; n++) begin
      run_op(rnd128(), rnd128(), 1'b1, GOOD | ({$urandom} & 32'h03FF_F800),
             n % 3, "R1 R2 R3 random", 1'b0, '0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule